// File: doc/BRIEF.md
# Runtime-Reprogrammable Clock Divider

This block sits behind a free-running source oscillator and produces a system clock at the source rate divided by a programmable factor. The factor is `DIV+1`, where `DIV` is a 4-bit value written from a separate register-write clock domain. After reset the factor is 12, which gives a 4 MHz output from a 48 MHz source. This default is not a power of two.

A write is handed to the oscillator domain through a toggle request/acknowledge handshake. Each direction uses a two-flop synchronizer. The writer sees `sync_busy` from the accepted write until the acknowledge has come back. The oscillator domain switches to the new factor only at the end of a complete output period, so no output phase is ever cut short.

Writes are accepted only while the oscillator is reported running and on-demand mode is off. A write that arrives while a transfer is still in flight is dropped and raises a one-cycle error pulse.

Top module: `clkdiv_live`

## Requirements
- R1: With `DIV=d` the output period is `N=d+1` source cycles. It is high for `(N+1)/2` cycles and low for `N/2` cycles, starting high at the period boundary. When `d=0`, the output is the source clock itself.
- R2: After reset the factor is 12, so the output is high for 6 source cycles and low for 6. The output is low while reset is held, and the first rising edge comes at the first source rising edge after reset is released.
- R3: A write (`wr_en=1`) is accepted when `osc_running=1`, `ondemand=0` and `sync_busy=0`. An accepted write makes `sync_busy` read 1 from the next `wr_clk` cycle.
- R4: `sync_busy` stays 1 until the new factor has been installed in the oscillator domain and the acknowledge has passed back through two `wr_clk` flops. It then returns to 0.
- R5: A new factor takes effect only at a period boundary. The period in progress completes with its old high and low lengths.
- R6: A write with `osc_running=0` or `ondemand=1` (and `sync_busy=0`) is ignored. `sync_busy` stays 0, `wr_err` stays 0 and the factor is unchanged.
- R7: A write while `sync_busy=1` is ignored. `wr_err` is 1 for exactly the following `wr_clk` cycle, and the factor from the earlier write is the one installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Source oscillator clock |
| wr_clk | input | 1 | Register-write domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| wr_en | input | 1 | Write strobe for a new divide value (wr_clk domain) |
| wr_div | input | 4 | New DIV value; factor is DIV+1 |
| osc_running | input | 1 | Oscillator reported running; writes need it high |
| ondemand | input | 1 | On-demand mode active; writes need it low |
| clk_out | output | 1 | Divided clock |
| sync_busy | output | 1 | Transfer of a written value in progress |
| wr_err | output | 1 | One-cycle pulse: write dropped because a transfer was busy |

## Verification
The bench aims at the moments when the factor changes. These include moves into and out of the divide-by-one bypass and from odd to even factors. A design that switched mid-period would produce a short or long phase that the per-cycle model flags at once. Odd factors check the one-cycle duty split; an off-by-one in the half-period compare shows up as a wrong high count. Writes dropped because of `osc_running`, `ondemand` or a busy transfer are followed by period measurements. These catch a design that let a dropped value leak through. A busy flag that cleared before the install, or an error pulse of the wrong length, is caught by the writer-side comparison on every `wr_clk` edge.

// File: rtl/clkdiv_live_pkg.sv
package clkdiv_live_pkg;
   // high-phase length for a period of n source cycles (rounded up)
   function automatic int unsigned high_len(input int unsigned n);
      return (n + 1) / 2;
   endfunction
endpackage

// File: rtl/clkdiv_live_sync.sv
module clkdiv_live_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkdiv_live_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clkdiv_live_wr_port.sv
module clkdiv_live_wr_port #(
   parameter int DIV_W       = 4,
   parameter int RESET_DIV   = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic             wr_clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DIV_W-1:0] wr_div,
   input  logic             osc_running,
   input  logic             ondemand,
   input  logic             ack_tgl,
   output logic             req_tgl,
   output logic [DIV_W-1:0] req_div,
   output logic             sync_busy,
   output logic             wr_err
);
   logic ack_seen, req_q, err_q, take;
   logic [DIV_W-1:0] div_hold;

   clkdiv_live_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(wr_clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_seen)
   );

   assign sync_busy = (req_q != ack_seen);
   assign take      = wr_en && osc_running && !ondemand && !sync_busy;

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q    <= 1'b0;
         div_hold <= DIV_W'(RESET_DIV);
         err_q    <= 1'b0;
      end else begin
         err_q <= wr_en && sync_busy;
         if (take) begin
            req_q    <= ~req_q;
            div_hold <= wr_div;
         end
      end
   end

   assign req_tgl = req_q;
   assign req_div = div_hold;
   assign wr_err  = err_q;

   // R3: an accepted write shows busy on the next cycle
   p_busy_after_take_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
      take |=> sync_busy);
   // R6: blocked writes leave the request untouched
   p_blocked_ignored_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_en && !sync_busy && (!osc_running || ondemand)) |=> $stable(req_q));
   // R7: error pulse only after a write during busy
   p_err_cause_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
      wr_err |-> $past(wr_en && sync_busy));
   // R4: held value never changes while a transfer is in flight
   p_hold_stable_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
      sync_busy |=> (!sync_busy || $stable(div_hold)));
endmodule

// File: rtl/clkdiv_live_core.sv
module clkdiv_live_core
   import clkdiv_live_pkg::*;
#(
   parameter int DIV_W       = 4,
   parameter int RESET_DIV   = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic             osc_clk,
   input  logic             rst_n,
   input  logic             req_tgl,
   input  logic [DIV_W-1:0] req_div,
   output logic             ack_tgl,
   output logic             clk_out
);
   localparam int N_W     = DIV_W + 1;
   localparam int RESET_N = RESET_DIV + 1;

   logic           req_now, req_prev, pend, ack_q;
   logic [N_W-1:0] act_n, cnt, new_n, half_n;
   logic           div_q, bypass, last;

   clkdiv_live_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(osc_clk), .rst_n(rst_n), .d(req_tgl), .q(req_now)
   );

   assign last   = (cnt == act_n - N_W'(1));
   assign new_n  = N_W'(req_div) + N_W'(1);
   assign half_n = N_W'(high_len(32'(act_n)));

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         req_prev <= 1'b0;
         pend     <= 1'b0;
         ack_q    <= 1'b0;
         act_n    <= N_W'(RESET_N);
         cnt      <= N_W'(RESET_DIV);
         div_q    <= 1'b0;
         bypass   <= (RESET_DIV == 0);
      end else begin
         req_prev <= req_now;
         if (req_now != req_prev) pend <= 1'b1;
         if (last) begin
            cnt   <= '0;
            div_q <= 1'b1;
            if (pend) begin
               act_n  <= new_n;
               bypass <= (req_div == '0);
               pend   <= 1'b0;
               ack_q  <= ~ack_q;
            end
         end else begin
            cnt   <= cnt + N_W'(1);
            div_q <= (cnt + N_W'(1)) < half_n;
         end
      end
   end

   assign ack_tgl = ack_q;
   assign clk_out = bypass ? osc_clk : div_q;

   // R1: phase counter stays inside the active period
   p_cnt_in_period_r1: assert property (@(posedge osc_clk) disable iff (!rst_n)
      cnt < act_n);
   // R1: the divided level rises only at the start of a period
   p_rise_at_start_r1: assert property (@(posedge osc_clk) disable iff (!rst_n)
      $rose(div_q) |-> (cnt == '0));
   // R5: factor changes only after the last cycle of a period
   p_switch_at_boundary_r5: assert property (@(posedge osc_clk) disable iff (!rst_n)
      !$stable(act_n) |-> (cnt == '0));
endmodule

// File: rtl/clkdiv_live.sv
module clkdiv_live #(
   parameter int DIV_W       = 4,
   parameter int RESET_DIV   = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic             osc_clk,
   input  logic             wr_clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DIV_W-1:0] wr_div,
   input  logic             osc_running,
   input  logic             ondemand,
   output logic             clk_out,
   output logic             sync_busy,
   output logic             wr_err
);
   generate
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_width
         $error("clkdiv_live: DIV_W out of range");
      end
      if (RESET_DIV < 0 || RESET_DIV >= (1 << DIV_W)) begin : g_bad_reset
         $error("clkdiv_live: RESET_DIV does not fit DIV_W");
      end
   endgenerate

   logic             req_tgl, ack_tgl;
   logic [DIV_W-1:0] req_div;

   clkdiv_live_wr_port #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV), .SYNC_STAGES(SYNC_STAGES)) u_wr (
      .wr_clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_div(wr_div),
      .osc_running(osc_running), .ondemand(ondemand), .ack_tgl(ack_tgl),
      .req_tgl(req_tgl), .req_div(req_div), .sync_busy(sync_busy), .wr_err(wr_err)
   );

   clkdiv_live_core #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV), .SYNC_STAGES(SYNC_STAGES)) u_core (
      .osc_clk(osc_clk), .rst_n(rst_n), .req_tgl(req_tgl), .req_div(req_div),
      .ack_tgl(ack_tgl), .clk_out(clk_out)
   );
endmodule

// File: tb/clkdiv_live_tb_top.sv
module clkdiv_live_tb_top;
   localparam int OSC_HALF = 5;
   localparam int WR_HALF  = 8;
   localparam int LIMIT    = 150000;

   logic osc_clk = 1'b0, wr_clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0, osc_running = 1'b1, ondemand = 1'b0;
   logic [3:0] wr_div = '0;
   logic clk_out, sync_busy, wr_err;

   int n_chk = 0, n_err = 0, osc_cyc = 0;
   bit done = 1'b0;
   string tag = "R2";

   always #OSC_HALF osc_clk = ~osc_clk;
   initial begin #3; forever #WR_HALF wr_clk = ~wr_clk; end

   clkdiv_live dut_i (
      .osc_clk(osc_clk), .wr_clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_div(wr_div), .osc_running(osc_running), .ondemand(ondemand),
      .clk_out(clk_out), .sync_busy(sync_busy), .wr_err(wr_err)
   );

   task automatic check(input bit ok, input string t, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d at %0t", t, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int m_n = 12, m_ph = 11, m_pend = 0, m_byp = 0, m_lvl = 0, m_ack = 0;
   int s1 = 0, s2 = 0, s3 = 0;
   int m_req = 0, m_a1 = 0, m_a2 = 0, m_err = 0, m_data = 11;

   always @(posedge osc_clk) begin
      osc_cyc++;
      if (!rst_n) begin
         m_n = 12; m_ph = 11; m_pend = 0; m_byp = 0; m_lvl = 0; m_ack = 0;
         s1 = 0; s2 = 0; s3 = 0;
      end else begin
         int seen_edge;
         seen_edge = (s2 != s3);
         if (m_ph == m_n - 1) begin
            m_ph = 0;
            if (m_pend != 0) begin
               m_n = m_data + 1; m_byp = (m_n == 1); m_pend = 0; m_ack ^= 1;
            end
         end else m_ph++;
         if (seen_edge != 0) m_pend = 1;
         s3 = s2; s2 = s1; s1 = m_req;
         m_lvl = (m_ph < (m_n + 1) / 2) ? 1 : 0;
      end
   end

   always @(posedge wr_clk) begin
      if (!rst_n) begin
         m_req = 0; m_a1 = 0; m_a2 = 0; m_err = 0; m_data = 11;
      end else begin
         int busy;
         busy  = (m_req != m_a2);
         m_err = (wr_en && busy != 0) ? 1 : 0;
         if (wr_en && osc_running && !ondemand && busy == 0) begin
            m_req ^= 1; m_data = int'(wr_div);
         end
         m_a2 = m_a1; m_a1 = m_ack;
      end
   end

   // per-cycle comparison of the divided clock (R1 / R5 / R2 by phase)
   always begin
      @(posedge osc_clk); #1;
      check(int'(clk_out) == m_lvl, {tag, " clk_out high-phase sample"}, int'(clk_out), m_lvl);
      @(negedge osc_clk); #1;
      check(int'(clk_out) == ((m_byp != 0) ? 0 : m_lvl), {tag, " clk_out low-phase sample"},
            int'(clk_out), (m_byp != 0) ? 0 : m_lvl);
   end

   // per-cycle comparison of the writer side (R3 / R4 / R7)
   always begin
      @(posedge wr_clk); #2;
      check(int'(sync_busy) == int'(m_req != m_a2), "R3/R4 sync_busy",
            int'(sync_busy), int'(m_req != m_a2));
      check(int'(wr_err) == m_err, "R7 wr_err", int'(wr_err), m_err);
   end

   task automatic do_write(input int d);
      @(negedge wr_clk); wr_en = 1'b1; wr_div = 4'(d);
      @(negedge wr_clk); wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200; i++) begin
         @(negedge wr_clk);
         if (!sync_busy) break;
      end
      check(!sync_busy, "R4 busy clears after install", int'(sync_busy), 0);
   endtask

   task automatic measure(output int per, output int hi);
      bit prev;
      do begin @(posedge osc_clk); #1; end while (clk_out);
      do begin @(posedge osc_clk); #1; end while (!clk_out);
      per = 1; hi = 1; prev = 1'b1;
      forever begin
         @(posedge osc_clk); #1;
         if (clk_out && !prev) break;
         per++;
         if (clk_out) hi++;
         prev = clk_out;
      end
   endtask

   task automatic expect_period(input int n, input string t);
      int per, hi;
      measure(per, hi);
      check(per == n, {t, " period"}, per, n);
      check(hi == (n + 1) / 2, {t, " high length"}, hi, (n + 1) / 2);
   endtask

   initial begin
      #50;
      check(clk_out == 1'b0, "R2 clk_out low in reset", int'(clk_out), 0);
      check(sync_busy == 1'b0, "R2 busy low in reset", int'(sync_busy), 0);
      check(wr_err == 1'b0, "R2 err low in reset", int'(wr_err), 0);
      #50 rst_n = 1'b1;
      @(posedge osc_clk); #1;
      check(clk_out == 1'b1, "R2 first rise after reset", int'(clk_out), 1);
      expect_period(12, "R2");

      tag = "R5";
      do_write(2);
      #1 check(sync_busy == 1'b1, "R3 busy after accepted write", int'(sync_busy), 1);
      wait_idle();
      tag = "R1";
      expect_period(3, "R1 odd factor");

      tag = "R5";
      do_write(0);
      wait_idle();
      tag = "R1";
      repeat (10) @(posedge osc_clk);
      tag = "R5";
      do_write(5);
      wait_idle();
      tag = "R1";
      expect_period(6, "R1 leave bypass");

      osc_running = 1'b0;
      do_write(9);
      #1 check(sync_busy == 1'b0, "R6 ignored while stopped", int'(sync_busy), 0);
      check(wr_err == 1'b0, "R6 no error while stopped", int'(wr_err), 0);
      osc_running = 1'b1;
      ondemand = 1'b1;
      do_write(9);
      #1 check(sync_busy == 1'b0, "R6 ignored in on-demand", int'(sync_busy), 0);
      ondemand = 1'b0;
      expect_period(6, "R6 factor unchanged");

      tag = "R5";
      @(negedge wr_clk); wr_en = 1'b1; wr_div = 4'd7;
      @(negedge wr_clk); wr_div = 4'd1;
      @(negedge wr_clk); wr_en = 1'b0;
      check(wr_err == 1'b1, "R7 error pulse on busy write", int'(wr_err), 1);
      @(negedge wr_clk);
      check(wr_err == 1'b0, "R7 error pulse one cycle", int'(wr_err), 0);
      wait_idle();
      tag = "R1";
      expect_period(8, "R7 first value kept");

      tag = "R5";
      do_write(15);
      wait_idle();
      tag = "R1";
      expect_period(16, "R1 max factor");
      tag = "R5";
      do_write(1);
      wait_idle();
      tag = "R1";
      expect_period(2, "R1 factor two");

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   always @(posedge osc_clk) begin
      if (!done && osc_cyc > LIMIT) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: got %0d cycles expected below %0d", osc_cyc, LIMIT);
         $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule